// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block runs one short SPI flash transaction at a time. Software fills a bank of six byte-wide transmit registers, puts the number of bits in a count register and sets one bit in a command register. The engine then pulls chip select low, shifts the frame out most significant bit first on a single data line in SPI mode 0, and shifts every sampled input bit into a bank of six byte-wide capture registers. The command bit reads back as 1 while the transfer runs and clears itself when chip select rises again.

Besides the generic transfer there are two fixed commands. One reads the flash status byte into its own register. The other writes one status byte, taken from the top transmit register. No command starts until an arming register holds the key value. A start written while a command runs is dropped.

Register map on the 5-bit byte-wide bus: 0x00 command (bit 2 generic transfer, bit 1 status read, bit 5 status write), 0x01 bit count, 0x02 status byte, 0x03 arming register, 0x08+n transmit register n (n = 0..5), 0x10+n capture register n (n = 0..5). Read data is registered and appears one clock after the address.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset the command register reads 0x00, the arming register reads 0x00, the status byte reads 0x00, chip select is high and SCK is low.
- R2: A write to the command register has no effect (no chip select, the command register stays 0x00) unless the last value written to the arming register (0x03) was 0x30. Writing 0x30 makes the arming register read 0x01. Writing any other value makes it read 0x00 and disarms the block.
- R3: Setting bit 2 (value 0x04) of the command register shifts out the frame built from transmit register 5 (the opcode) down to transmit register 0, followed by one zero byte. The frame goes out most significant bit first, with exactly as many SCK rising edges as the bit count.
- R4: Each received bit is sampled on an SCK rising edge and shifted into the capture chain. After a transfer of k bytes, capture register n (n < k, n < 6) holds the byte received n bytes before the last one, so capture register 0 holds the last byte.
- R5: A bit count above 56 is treated as 56. A generic transfer with a bit count of 0 starts nothing and leaves the command register at 0x00.
- R6: Setting bit 1 (value 0x02) sends opcode 0x05 and then 8 more clocks. The second byte received is placed in the status byte register (0x02).
- R7: Setting bit 5 (value 0x20) sends opcode 0x01 and then the byte in transmit register 5, 16 clocks in all.
- R8: The started command's bit reads back as 1 while it runs and clears after chip select rises. If several bits are written at once, the generic transfer wins over the status read, and the status read wins over the status write.
- R9: A command write that arrives while a command is running is ignored: no second transfer takes place and the status byte is unchanged.
- R10: SCK idles low and has a period of CLK_DIV clocks. MOSI changes only while SCK is low. The first rising edge comes 1.5 SCK periods after chip select falls, and chip select rises half an SCK period after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The generic transfer is swept over every whole-byte frame length from one to seven bytes. The transmit and response patterns depend on the length, so a frame that is cut short or shifted by a byte, or a capture byte in the wrong register, shows up as a mismatch. Further runs cover bit counts that are not byte multiples (13), that must be clamped (60) and that are zero. They separate the per-bit counter from the byte framing. The two fixed commands, a write of several command bits at once and a start during a running command tell the command decoding and its gating apart from the shifter. The edge timestamps taken on one transfer pin down the chip select lead, the SCK period and the chip select trail.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CMD = 5'h00;
  localparam logic [ADDR_W-1:0] A_CNT = 5'h01;
  localparam logic [ADDR_W-1:0] A_SR  = 5'h02;
  localparam logic [ADDR_W-1:0] A_ARM = 5'h03;
  localparam logic [1:0]        PAGE_TX  = 2'b01;
  localparam logic [1:0]        PAGE_CAP = 2'b10;

  localparam int CB_PROG = 2;
  localparam int CB_RDSR = 1;
  localparam int CB_WRSR = 5;

  typedef enum logic [1:0] {K_PROG, K_RDSR, K_WRSR} cmd_kind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_st_t;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int         NPROG      = 6,
  parameter logic [7:0] RDSR_OP    = 8'h05,
  parameter logic [7:0] WRSR_OP    = 8'h01,
  parameter logic [7:0] ARM_KEY    = 8'h30,
  localparam int        FRAME_BITS = 8 * (NPROG + 1),
  localparam int        CAP_BITS   = 8 * NPROG,
  localparam int        NW         = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  input  logic                  we,
  output logic [7:0]            rdata,
  input  logic                  eng_done,
  input  logic [CAP_BITS-1:0]   rx,
  output logic                  start,
  output logic [FRAME_BITS-1:0] frame,
  output logic [NW-1:0]         nbits
);

  logic [7:0]      prog_q [NPROG];
  logic [7:0]      cnt_q;
  logic [7:0]      cmd_q;
  logic [7:0]      stat_q;
  logic            arm_q;
  cmd_kind_t       kind_q;
  logic [FRAME_BITS-1:0] prog_frame;
  logic [NW-1:0]   eff_bits;
  logic            cmd_hit;
  logic            accept;
  logic [7:0]      rd_c;

  always_comb begin
    prog_frame = '0;
    for (int i = 0; i < NPROG; i++)
      prog_frame[FRAME_BITS-1-8*i -: 8] = prog_q[NPROG-1-i];
  end

  assign eff_bits = (cnt_q > 8'(FRAME_BITS)) ? NW'(FRAME_BITS) : cnt_q[NW-1:0];
  assign cmd_hit  = we && (addr == A_CMD);
  assign accept   = cmd_hit && arm_q && (cmd_q == 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPROG; i++) prog_q[i] <= 8'h00;
      cnt_q  <= 8'h00;
      arm_q  <= 1'b0;
    end else if (we) begin
      for (int i = 0; i < NPROG; i++)
        if (addr == {PAGE_TX, 3'(i)}) prog_q[i] <= wdata;
      if (addr == A_CNT) cnt_q <= wdata;
      if (addr == A_ARM) arm_q <= (wdata == ARM_KEY);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 8'h00;
      stat_q <= 8'h00;
      start  <= 1'b0;
      frame  <= '0;
      nbits  <= '0;
      kind_q <= K_PROG;
    end else begin
      start <= 1'b0;
      if (eng_done) begin
        cmd_q <= 8'h00;
        if (kind_q == K_RDSR) stat_q <= rx[7:0];
      end else if (accept) begin
        if (wdata[CB_PROG]) begin
          if (eff_bits != '0) begin
            cmd_q[CB_PROG] <= 1'b1;
            kind_q <= K_PROG;
            frame  <= prog_frame;
            nbits  <= eff_bits;
            start  <= 1'b1;
          end
        end else if (wdata[CB_RDSR]) begin
          cmd_q[CB_RDSR] <= 1'b1;
          kind_q <= K_RDSR;
          frame  <= {RDSR_OP, (FRAME_BITS-8)'(0)};
          nbits  <= NW'(16);
          start  <= 1'b1;
        end else if (wdata[CB_WRSR]) begin
          cmd_q[CB_WRSR] <= 1'b1;
          kind_q <= K_WRSR;
          frame  <= {WRSR_OP, prog_q[NPROG-1], (FRAME_BITS-16)'(0)};
          nbits  <= NW'(16);
          start  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_c = 8'h00;
    case (addr)
      A_CMD:   rd_c = cmd_q;
      A_CNT:   rd_c = cnt_q;
      A_SR:    rd_c = stat_q;
      A_ARM:   rd_c = {7'b0, arm_q};
      default: begin
        for (int i = 0; i < NPROG; i++) begin
          if (addr == {PAGE_TX, 3'(i)})  rd_c = prog_q[i];
          if (addr == {PAGE_CAP, 3'(i)}) rd_c = rx[8*i +: 8];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_c;
  end

  // R8: at most one command bit is ever pending
  assert_one_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_q));

  // R9: a command write during a running command leaves the command bits alone
  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && (cmd_q != 8'h00) && !eng_done) |=> (cmd_q == $past(cmd_q)));

  // R2: a transfer is only launched while the block is armed
  assert_armed_start_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(arm_q));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int  CLK_DIV    = 4,
  parameter int  FRAME_BITS = 56,
  parameter int  CAP_BITS   = 48,
  localparam int HALF       = CLK_DIV / 2,
  localparam int CW         = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1,
  localparam int NW         = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic [NW-1:0]         nbits,
  input  logic                  miso,
  output logic                  done,
  output logic                  cs_n,
  output logic                  sck,
  output logic                  mosi,
  output logic [CAP_BITS-1:0]   rx
);

  eng_st_t               st;
  logic [CW-1:0]         cnt;
  logic [NW-1:0]         left;
  logic [FRAME_BITS-1:0] tx;

  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);

  assign mosi = tx[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      left <= '0;
      tx   <= '0;
      rx   <= '0;
      cs_n <= 1'b1;
      sck  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            tx   <= frame;
            left <= nbits;
            cs_n <= 1'b0;
            cnt  <= '0;
            st   <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            st  <= ST_SHIFT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cnt == CNT_MID) begin
            sck <= 1'b1;
            rx  <= {rx[CAP_BITS-2:0], miso};
          end
          if (cnt == CNT_LAST) begin
            sck  <= 1'b0;
            cnt  <= '0;
            tx   <= tx << 1;
            left <= left - 1'b1;
            if (left == NW'(1)) st <= ST_TRAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CNT_MID) begin
            cs_n <= 1'b1;
            done <= 1'b1;
            cnt  <= '0;
            st   <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R10: clock pulses only inside an asserted chip select
  assert_sck_framed_R10: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n);

  // R10: data line moves only while SCK is low
  assert_mosi_low_phase_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> !sck);

  // R9: the register side never launches into a running transfer
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> (st == ST_IDLE));

  // R5: the remaining bit count never exceeds the frame size
  assert_bits_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    left <= NW'(FRAME_BITS));

  // R3: chip select only falls in response to a start
  assert_cs_from_start_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(start));

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int         CLK_DIV    = 4,
  parameter int         NPROG      = 6,
  parameter logic [7:0] RDSR_OP    = 8'h05,
  parameter logic [7:0] WRSR_OP    = 8'h01,
  parameter logic [7:0] ARM_KEY    = 8'h30,
  localparam int        FRAME_BITS = 8 * (NPROG + 1),
  localparam int        CAP_BITS   = 8 * NPROG,
  localparam int        NW         = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  logic                  start;
  logic                  done;
  logic [FRAME_BITS-1:0] frame;
  logic [NW-1:0]         nbits;
  logic [CAP_BITS-1:0]   rx;

  spi_cmd_regs #(
    .NPROG   (NPROG),
    .RDSR_OP (RDSR_OP),
    .WRSR_OP (WRSR_OP),
    .ARM_KEY (ARM_KEY)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we),
    .rdata    (reg_rdata),
    .eng_done (done),
    .rx       (rx),
    .start    (start),
    .frame    (frame),
    .nbits    (nbits)
  );

  spi_cmd_engine #(
    .CLK_DIV    (CLK_DIV),
    .FRAME_BITS (FRAME_BITS),
    .CAP_BITS   (CAP_BITS)
  ) u_engine (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .frame (frame),
    .nbits (nbits),
    .miso  (spi_miso),
    .done  (done),
    .cs_n  (spi_cs_n),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .rx    (rx)
  );

endmodule

// File: tb/spi_cmd_shifter_tb.sv
module spi_cmd_shifter_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] a   = 5'h00;
  logic [7:0] wd  = 8'h00;
  logic       we  = 1'b0;
  logic [7:0] rdv;
  logic       cs_n, sck, mosi, miso;

  always #5 clk = ~clk;

  spi_cmd_shifter u_dut (
    .clk(clk), .rst(rst), .reg_addr(a), .reg_wdata(wd), .reg_we(we),
    .reg_rdata(rdv), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso)
  );

  // flash-side model
  int          nrise = 0, nfall = 0, ncs = 0, fall_base = 0, rise_at_cs = 0;
  longint      t_csf = 0, t_first = 0, t_prev = 0, t_lrise = 0, t_lfall = 0, t_csr = 0;
  logic [63:0] mlog = '0;
  logic [55:0] resp = '0;
  int          bidx;

  always @(negedge cs_n) begin
    ncs++; fall_base = nfall; rise_at_cs = nrise; t_csf = $time;
  end
  always @(posedge sck) begin
    if (nrise == rise_at_cs) t_first = $time;
    t_prev = t_lrise; t_lrise = $time;
    nrise++;
    mlog = {mlog[62:0], mosi};
  end
  always @(negedge sck) begin
    nfall++; t_lfall = $time;
  end
  always @(posedge cs_n) t_csr = $time;

  assign bidx = nfall - fall_base;
  assign miso = (bidx >= 0 && bidx < 56) ? resp[55 - bidx] : 1'b0;

  int ncmp = 0, nerr = 0;
  logic [7:0] pv [6];
  logic [7:0] rv [7];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] ad, input logic [7:0] d);
    @(negedge clk); a = ad; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ad, output logic [7:0] d);
    @(negedge clk); a = ad; we = 1'b0;
    @(negedge clk); d = rdv;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    int k = 0;
    do begin rd(5'h00, v); k++; end while (v != 8'h00 && k < 2000);
    chk(req, {56'h0, v}, 64'h0);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [55:0] prog_frame();
    logic [55:0] f = '0;
    for (int i = 0; i < 6; i++) f[55-8*i -: 8] = pv[5-i];
    return f;
  endfunction

  function automatic logic [63:0] top_bits(input logic [55:0] f, input int n);
    logic [63:0] m = (64'h1 << n) - 64'h1;
    return ({8'h0, f} >> (56 - n)) & m;
  endfunction

  task automatic load_patterns(input int seed);
    for (int i = 0; i < 6; i++) begin
      pv[i] = 8'(8'h3C + 8'(37 * i) + 8'(11 * seed));
      wr(5'h08 + 5'(i), pv[i]);
    end
    for (int k = 0; k < 7; k++) begin
      rv[k] = 8'(8'hC1 ^ 8'(29 * k + seed));
      resp[55-8*k -: 8] = rv[k];
    end
  endtask

  task automatic run_prog(input logic [7:0] cnt, input int expbits, input string req);
    int r0;
    logic [7:0] v;
    r0 = nrise;
    wr(5'h01, cnt);
    wr(5'h00, 8'h04);
    wait_idle("R8");
    chk(req, 64'(nrise - r0), 64'(expbits));
    chk(req, mlog & ((64'h1 << expbits) - 64'h1), top_bits(prog_frame(), expbits));
    v = 8'h0;
  endtask

  initial begin
    logic [7:0] v;
    int c0, r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h00, v); chk("R1", {56'h0, v}, 64'h00);
    rd(5'h03, v); chk("R1", {56'h0, v}, 64'h00);
    rd(5'h02, v); chk("R1", {56'h0, v}, 64'h00);
    chk("R1", {63'h0, cs_n}, 64'h1);
    chk("R1", {63'h0, sck}, 64'h0);

    // R2 unarmed command ignored
    c0 = ncs;
    wr(5'h01, 8'd8);
    wr(5'h00, 8'h04);
    rd(5'h00, v); chk("R2", {56'h0, v}, 64'h00);
    repeat (20) @(negedge clk);
    chk("R2", 64'(ncs - c0), 64'h0);
    wr(5'h03, 8'h30);
    rd(5'h03, v); chk("R2", {56'h0, v}, 64'h01);

    // R3 / R4 sweep over whole-byte frames 1..7 bytes
    for (int L = 1; L <= 7; L++) begin
      load_patterns(L);
      r0 = nrise;
      wr(5'h01, 8'(8 * L));
      wr(5'h00, 8'h04);
      rd(5'h00, v); chk("R8", {56'h0, v}, 64'h04);
      wait_idle("R8");
      chk("R3", 64'(nrise - r0), 64'(8 * L));
      chk("R3", mlog & ((64'h1 << (8 * L)) - 64'h1), top_bits(prog_frame(), 8 * L));
      for (int n = 0; n < 6 && n < L; n++) begin
        rd(5'h10 + 5'(n), v);
        chk("R4", {56'h0, v}, {56'h0, rv[L-1-n]});
      end
      if (L == 2) begin
        chk("R10", 64'(t_first - t_csf), 64'd60);
        chk("R10", 64'(t_lrise - t_prev), 64'd40);
        chk("R10", 64'(t_csr - t_lfall), 64'd20);
      end
    end

    // R3 non-byte count, R5 clamp and zero count
    load_patterns(9);
    run_prog(8'd13, 13, "R3");
    run_prog(8'd60, 56, "R5");
    c0 = ncs;
    wr(5'h01, 8'd0);
    wr(5'h00, 8'h04);
    rd(5'h00, v); chk("R5", {56'h0, v}, 64'h00);
    repeat (20) @(negedge clk);
    chk("R5", 64'(ncs - c0), 64'h0);

    // R6 status read
    load_patterns(3);
    r0 = nrise;
    wr(5'h00, 8'h02);
    rd(5'h00, v); chk("R8", {56'h0, v}, 64'h02);
    wait_idle("R8");
    chk("R6", 64'(nrise - r0), 64'd16);
    chk("R6", mlog & 64'hFFFF, 64'h0500);
    rd(5'h02, v); chk("R6", {56'h0, v}, {56'h0, rv[1]});

    // R7 status write
    load_patterns(4);
    r0 = nrise;
    wr(5'h00, 8'h20);
    rd(5'h00, v); chk("R8", {56'h0, v}, 64'h20);
    wait_idle("R8");
    chk("R7", 64'(nrise - r0), 64'd16);
    chk("R7", mlog & 64'hFFFF, {48'h0, 8'h01, pv[5]});

    // R9 start during busy ignored, status unchanged
    load_patterns(5);
    c0 = ncs;
    wr(5'h01, 8'd24);
    wr(5'h00, 8'h04);
    wr(5'h00, 8'h02);
    rd(5'h00, v); chk("R9", {56'h0, v}, 64'h04);
    wait_idle("R9");
    chk("R9", 64'(ncs - c0), 64'd1);
    rd(5'h02, v); chk("R9", {56'h0, v}, {56'h0, 8'(8'hC1 ^ 8'(29 + 3))});

    // R8 priority when several bits are written together
    load_patterns(6);
    r0 = nrise;
    wr(5'h01, 8'd24);
    wr(5'h00, 8'h26);
    rd(5'h00, v); chk("R8", {56'h0, v}, 64'h04);
    wait_idle("R8");
    chk("R8", 64'(nrise - r0), 64'd24);
    chk("R8", mlog & 64'hFFFFFF, top_bits(prog_frame(), 24));

    // R2 disarm with a wrong key
    wr(5'h03, 8'h31);
    rd(5'h03, v); chk("R2", {56'h0, v}, 64'h00);
    c0 = ncs;
    wr(5'h00, 8'h20);
    repeat (20) @(negedge clk);
    chk("R2", 64'(ncs - c0), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp + 1, nerr + 1);
    $finish;
  end

endmodule